// File: doc/BRIEF.md
# Hierarchical Tree Barrier

This block makes a set of hardware threads wait for each other at a barrier. It is organized as a two-level tree inside one memory stack, with a third level outside the stack. Threads are grouped into vaults. Each vault keeps an arrival counter that works like a fetch-and-add. Every thread that arrives takes the next count value. The thread that takes the last value becomes the vault's representative, and only that thread reports the vault upward to the stack level.

The stack level counts vault reports with the same scheme. When the last vault reports, the stack issues a single cross-stack message that names the representative vault and carries the current episode sense. The block then waits for a release from the system level. That release fans out to every thread as a one-cycle pulse, flips the sense bit and clears all counters, so the barrier can be used again without a reset. Transport of the cross-stack message is outside this block.

Top module: `tree_barrier`

## Requirements
- R1: After reset, `thr_release`, `vault_up` and `xs_send` are all zero and `sense` is 0.
- R2: `vault_up[v]` pulses high for exactly one cycle. The pulse comes one cycle after the clock edge at which the last not-yet-counted thread of vault v is sampled arriving. It never comes while any thread of that vault is still uncounted.
- R3: Arrivals sampled in the same cycle within a vault are counted lowest thread index first. While `vault_up[v]` is high, `vault_rep[v*TW +: TW]` holds the in-vault index of the thread that took the final count value.
- R4: An arrival from a thread that has already been counted in the current episode is ignored and does not advance the count.
- R5: `xs_send` is a one-cycle pulse that comes one cycle after the cycle in which the last vault's `vault_up` is high. Vaults reporting in the same cycle are counted lowest index first, and `xs_rep` holds the index of the vault that took the final count.
- R6: Exactly one `xs_send` is issued per episode, and none is issued before every vault has reported.
- R7: `xs_release` has no effect while the stack has not yet sent its message.
- R8: When `xs_release` is sampled after `xs_send`, the next cycle has every bit of `thr_release` high for exactly one cycle, and `sense` toggles in that same cycle.
- R9: `xs_sense` equals `sense` of the episode being completed. A second episode completes with the opposite sense, and no reset is needed between episodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_arrive | input | VAULTS*THREADS | Per-thread arrival strobe; thread t of vault v is bit v*THREADS+t |
| thr_release | output | VAULTS*THREADS | Per-thread release pulse |
| sense | output | 1 | Current episode sense |
| vault_up | output | VAULTS | Vault-complete pulse toward the stack level |
| vault_rep | output | VAULTS*TW | Representative thread index per vault, valid with vault_up |
| xs_send | output | 1 | Cross-stack arrival message strobe |
| xs_rep | output | VW | Representative vault index, valid with xs_send |
| xs_sense | output | 1 | Episode sense carried by the message |
| xs_release | input | 1 | Release from the system level |

## Verification
The hardest situation to produce is counter ordering when several threads, and several vaults, complete in the same cycle. In that case the representative must be the last one in index order and not simply any one of the arrivals. The stimulus gets there by leaving one vault short by a single thread and then driving that thread in the same cycle as every thread of a second vault. This makes two vaults report together, so both the in-vault representative and the stack-level representative are checked from one edge. Duplicate arrivals, both before completion and while the stack waits for release, are placed where a miscount would complete a vault early or produce a second message.

// File: rtl/tree_barrier.sv
module tree_barrier #(
  parameter int THREADS = 4,
  parameter int VAULTS  = 4,
  localparam int N  = THREADS * VAULTS,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int VW = (VAULTS > 1) ? $clog2(VAULTS) : 1,
  localparam int CW = $clog2(THREADS + 1),
  localparam int SW = $clog2(VAULTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     thr_arrive,
  output logic [N-1:0]     thr_release,
  output logic             sense,
  output logic [VAULTS-1:0] vault_up,
  output logic [VAULTS*TW-1:0] vault_rep,
  output logic             xs_send,
  output logic [VW-1:0]    xs_rep,
  output logic             xs_sense,
  input  logic             xs_release
);

  logic          waiting, sense_q, rel_q, send_q;
  logic [SW-1:0] scnt, snxt;
  logic [VW-1:0] slast, rep_q;
  wire           release_go = xs_release & waiting;

  for (genvar v = 0; v < VAULTS; v++) begin : g_vault
    logic [THREADS-1:0] req, arr_q;
    logic [CW-1:0]      cnt, cnt_nxt;
    logic [TW-1:0]      last, vrep_q;
    logic               up_q;

    assign req = thr_arrive[v*THREADS +: THREADS] & ~arr_q & {THREADS{~waiting}};

    always_comb begin
      cnt_nxt = cnt;
      last    = '0;
      for (int i = 0; i < THREADS; i++)
        if (req[i]) begin
          cnt_nxt = cnt_nxt + CW'(1);
          last    = TW'(i);
        end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || release_go) begin
        cnt    <= '0;
        arr_q  <= '0;
        up_q   <= 1'b0;
        vrep_q <= '0;
      end else begin
        cnt   <= cnt_nxt;
        arr_q <= arr_q | req;
        up_q  <= (cnt_nxt == CW'(THREADS)) && (cnt != CW'(THREADS));
        if ((cnt_nxt == CW'(THREADS)) && (cnt != CW'(THREADS))) vrep_q <= last;
      end
    end

    assign vault_up[v] = up_q;
    assign vault_rep[v*TW +: TW] = vrep_q;
  end

  always_comb begin
    snxt  = scnt;
    slast = '0;
    for (int v = 0; v < VAULTS; v++)
      if (vault_up[v]) begin
        snxt  = snxt + SW'(1);
        slast = VW'(v);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt    <= '0;
      waiting <= 1'b0;
      sense_q <= 1'b0;
      rel_q   <= 1'b0;
      send_q  <= 1'b0;
      rep_q   <= '0;
    end else if (release_go) begin
      scnt    <= '0;
      waiting <= 1'b0;
      sense_q <= ~sense_q;
      rel_q   <= 1'b1;
      send_q  <= 1'b0;
    end else begin
      rel_q  <= 1'b0;
      scnt   <= snxt;
      send_q <= (snxt == SW'(VAULTS)) && (scnt != SW'(VAULTS));
      if ((snxt == SW'(VAULTS)) && (scnt != SW'(VAULTS))) begin
        rep_q   <= slast;
        waiting <= 1'b1;
      end
    end
  end

  assign thr_release = {N{rel_q}};
  assign sense       = sense_q;
  assign xs_send     = send_q;
  assign xs_rep      = rep_q;
  assign xs_sense    = sense_q;

endmodule

// File: rtl/tree_barrier_chk.sv
module tree_barrier_chk #(
  parameter int THREADS = 4,
  parameter int VAULTS  = 4,
  localparam int N  = THREADS * VAULTS,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int VW = (VAULTS > 1) ? $clog2(VAULTS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     thr_arrive,
  input logic [N-1:0]     thr_release,
  input logic             sense,
  input logic [VAULTS-1:0] vault_up,
  input logic [VAULTS*TW-1:0] vault_rep,
  input logic             xs_send,
  input logic [VW-1:0]    xs_rep,
  input logic             xs_sense,
  input logic             xs_release
);

  assert_release_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_release == '0) || (&thr_release));

  assert_release_flips_sense_R8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_release[0] |-> sense != $past(sense));

  assert_release_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_release[0] |=> !thr_release[0]);

  assert_send_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xs_send |=> !xs_send);

  assert_vault_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vault_up != '0) |=> ((vault_up & $past(vault_up)) == '0));

  assert_msg_sense_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xs_send |-> xs_sense == sense);

  assert_no_send_and_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(xs_send && thr_release[0]));

endmodule

bind tree_barrier tree_barrier_chk #(.THREADS(THREADS), .VAULTS(VAULTS)) u_chk (.*);

// File: tb/tree_barrier_tb.sv
module tree_barrier_tb;
  localparam int T = 4, V = 4, N = 16, TW = 2, VW = 2;

  logic clk = 0, rst_n = 0, xs_release = 0;
  logic [N-1:0] thr_arrive = '0;
  logic [N-1:0] thr_release;
  logic sense, xs_send, xs_sense;
  logic [V-1:0] vault_up;
  logic [V*TW-1:0] vault_rep;
  logic [VW-1:0] xs_rep;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tree_barrier #(.THREADS(T), .VAULTS(V)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] m, input logic rel = 1'b0);
    thr_arrive = m;
    xs_release = rel;
    @(posedge clk);
    @(negedge clk);
    thr_arrive = '0;
    xs_release = 0;
  endtask

  task automatic t_reset();
    check(thr_release == 0, "R1 release", thr_release, 0);
    check(vault_up == 0, "R1 vault_up", vault_up, 0);
    check(xs_send == 0, "R1 xs_send", xs_send, 0);
    check(sense == 0, "R1 sense", sense, 0);
  endtask

  task automatic t_vault0();
    step(16'h0007);
    check(vault_up == 0, "R2 early", vault_up, 0);
    step(16'h0008);
    check(vault_up == 4'b0001, "R2 vault0 up", vault_up, 1);
    check(vault_rep[1:0] == 3, "R3 vault0 rep", vault_rep[1:0], 3);
    step('0);
    check(vault_up == 0, "R2 pulse width", vault_up, 0);
  endtask

  task automatic t_duplicate();
    step(16'h0010);
    step(16'h0010);
    step(16'h0060);
    check(vault_up == 0, "R4 duplicate ignored", vault_up, 0);
    step(16'h0080);
    check(vault_up == 4'b0010, "R4 vault1 up", vault_up, 2);
    check(vault_rep[3:2] == 3, "R3 vault1 rep", vault_rep[3:2], 3);
  endtask

  task automatic t_early_release();
    step('0, 1'b1);
    check(thr_release == 0, "R7 no release", thr_release, 0);
    check(sense == 0, "R7 sense kept", sense, 0);
  endtask

  task automatic t_simultaneous();
    step(16'h0D00);
    check(vault_up == 0, "R2 vault2 short", vault_up, 0);
    step(16'hF200);
    check(vault_up == 4'b1100, "R2 two vaults", vault_up, 4'hC);
    check(vault_rep[5:4] == 1, "R3 vault2 rep", vault_rep[5:4], 1);
    check(vault_rep[7:6] == 3, "R3 vault3 rep", vault_rep[7:6], 3);
    check(xs_send == 0, "R6 no early send", xs_send, 0);
    step('0);
    check(xs_send == 1, "R5 send", xs_send, 1);
    check(xs_rep == 3, "R5 rep vault", xs_rep, 3);
    check(xs_sense == 0, "R9 sense0", xs_sense, 0);
    step(16'hFFFF);
    check(xs_send == 0, "R5 send pulse", xs_send, 0);
    step('0);
    check(vault_up == 0 && xs_send == 0, "R6 single message", {vault_up, 3'b0, xs_send}, 0);
  endtask

  task automatic t_release(input logic exp_sense);
    step('0, 1'b1);
    check(thr_release == 16'hFFFF, "R8 release all", thr_release, 16'hFFFF);
    check(sense == exp_sense, "R8 sense toggle", sense, exp_sense);
    step('0);
    check(thr_release == 0, "R8 release pulse", thr_release, 0);
  endtask

  task automatic t_second();
    step(16'hFF0F);
    check(vault_up == 4'b1101, "R2 ep2 three vaults", vault_up, 4'hD);
    step('0);
    check(xs_send == 0, "R6 ep2 wait", xs_send, 0);
    step(16'h00F0);
    check(vault_up == 4'b0010, "R2 ep2 vault1", vault_up, 2);
    step('0);
    check(xs_send == 1, "R9 ep2 send", xs_send, 1);
    check(xs_rep == 1, "R5 ep2 rep", xs_rep, 1);
    check(xs_sense == 1, "R9 sense1", xs_sense, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_vault0();
    t_duplicate();
    t_early_release();
    t_simultaneous();
    t_release(1'b1);
    t_second();
    t_release(1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule